// File: doc/BRIEF.md
# Floating-Point Stack Register Renamer

This block maps an eight-deep floating-point register stack onto physical locations for an out-of-order core. Every stack reference arrives relative to the current top of stack; the block adds the top-of-stack offset to form an absolute slot and reads a speculative mapping table at that slot. Each table entry says whether the value lives in a reorder-buffer entry (holding its tag) or in the retirement register file (holding a register number), together with a valid flag that marks an occupied stack slot. A renamed micro-op that writes the stack installs its allocated reorder-buffer tag in the table, and push or pop moves the top of stack.

An exchange of the top of stack with another slot is handled by swapping the two table entries. No data moves, no execution resource is used, and the exchange is reported complete in the cycle it is renamed. A second, nonspeculative table with its own top-of-stack pointer is changed only by retiring micro-ops, including retiring exchanges. A speculative entry whose tag retires falls back to the retirement register named by the retirement table. A source read in the very cycle its producer retires is overridden with that same value. On a flush, sent once everything up to a mispredicted branch has retired, the speculative table and top of stack are reloaded from the retirement copy.

Top module: `fpr_stack_rename`

## Requirements
- R1: After reset every speculative entry i is valid, not in the reorder buffer, and points to retirement register i; both tops of stack are 0.
- R2: The source lookup reads slot (top + ren_src_rel) mod 8 of the speculative table and returns its valid flag, its in-reorder-buffer flag and its pointer, the pointer being zero-extended.
- R3: ren_tos_adj encodes 0 = keep, 1 = push (top - 1 mod 8), 2 = pop (top + 1 mod 8), 3 = keep. A renamed non-exchange op applies it; a pop clears the valid flag of the old top slot, and a write with ren_dst_en stores {valid, in reorder buffer, ren_tag} at slot (new top + ren_dst_rel) mod 8.
- R4: A renamed exchange (ren_xch = 1) swaps the whole entries at the top slot and at slot (top + ren_src_rel) mod 8 and leaves the top of stack unchanged; ren_src_rel = 0 changes nothing.
- R5: ren_done is 1 in exactly the cycles in which an exchange is renamed and no flush is present.
- R6: The retirement table changes only on ret_valid. A retiring exchange swaps its top entry with slot (rtop + ret_rel) mod 8; otherwise ret_tos_adj moves rtop with the R3 encoding, a pop clears the valid flag of the old retirement top, and ret_dst_en sets the valid flag of slot (new rtop + ret_rel) mod 8.
- R7: When a non-exchange retirement with ret_dst_en retires ret_tag, every speculative entry holding that tag in the reorder buffer switches to the retirement register recorded for the retiring slot, keeping its valid flag; a rename write to the same entry in the same cycle takes priority.
- R8: A source looked up in the cycle its tag retires (as in R7) is returned as not in the reorder buffer with the retirement register pointer of the retiring slot, taken after that cycle's retirement update.
- R9: A flush loads every speculative entry with the valid flag and register pointer of the retirement table after that cycle's retirement, marks none as in the reorder buffer, and sets the speculative top to the retirement top; any rename in the flush cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | A micro-op is presented for renaming |
| ren_xch | input | 1 | The micro-op is a stack exchange |
| ren_src_rel | input | 3 | Source stack index; the exchange partner when ren_xch is 1 |
| ren_dst_en | input | 1 | The micro-op writes a stack register |
| ren_dst_rel | input | 3 | Destination stack index, relative to the adjusted top |
| ren_tos_adj | input | 2 | Top-of-stack adjustment: 0 keep, 1 push, 2 pop |
| ren_tag | input | 6 | Reorder-buffer tag granted by the allocator |
| ren_src_valid | output | 1 | Looked-up slot holds a value |
| ren_src_in_rob | output | 1 | Looked-up value lives in the reorder buffer |
| ren_src_ptr | output | 6 | Reorder-buffer tag or retirement register number |
| ren_done | output | 1 | Exchange completed at rename |
| spec_tos | output | 3 | Speculative top of stack |
| ret_valid | input | 1 | A micro-op retires |
| ret_xch | input | 1 | The retiring micro-op is an exchange |
| ret_rel | input | 3 | Retiring destination or exchange partner index |
| ret_dst_en | input | 1 | The retiring micro-op wrote a stack register |
| ret_tos_adj | input | 2 | Retiring top-of-stack adjustment, same encoding |
| ret_tag | input | 6 | Reorder-buffer tag of the retiring micro-op |
| flush | input | 1 | Restore the speculative state from the retirement copy |

## Verification
Rename and retirement meet in one cycle in two ways: a source lookup hits the tag that is retiring, and a rename write lands on the very entry that a retirement would reset. The bench provokes both by driving a retirement together with a lookup or a write into the slot holding the retiring tag, and judges the same-cycle outputs and the next cycle's lookup against its own model of the two tables. A flush is also given together with a push and a retirement, and the restored lookups and top of stack must reflect the retirement and none of the push.

// File: rtl/fpr_pkg.sv
`timescale 1ns/1ps
package fpr_pkg;

  typedef enum logic [1:0] {
    ADJ_KEEP = 2'd0,
    ADJ_PUSH = 2'd1,
    ADJ_POP  = 2'd2,
    ADJ_RSVD = 2'd3
  } tos_adj_e;

  // Absolute slot from a top pointer and a relative index; n is a power of two.
  function automatic int unsigned slot_add(input int unsigned top, input int unsigned rel,
                                           input int unsigned n);
    return (top + rel) & (n - 1);
  endfunction

  // Top pointer after a push, pop or no adjustment.
  function automatic int unsigned top_step(input int unsigned top, input logic [1:0] adj,
                                           input int unsigned n);
    case (adj)
      ADJ_PUSH: return (top + n - 1) & (n - 1);
      ADJ_POP:  return (top + 1) & (n - 1);
      default:  return top;
    endcase
  endfunction

endpackage

// File: rtl/fpr_retire_table.sv
`timescale 1ns/1ps
module fpr_retire_table
  import fpr_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int SLOT_W = $clog2(NSLOT)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ret_valid,
  input  logic                             ret_xch,
  input  logic [SLOT_W-1:0]                ret_rel,
  input  logic                             ret_dst_en,
  input  logic [1:0]                       ret_tos_adj,
  output logic [NSLOT-1:0]                 nxt_val,
  output logic [NSLOT-1:0][SLOT_W-1:0]     nxt_ptr,
  output logic [SLOT_W-1:0]                nxt_top,
  output logic [SLOT_W-1:0]                ret_slot,
  output logic                             ret_write
);

  logic [NSLOT-1:0]             val_q;
  logic [NSLOT-1:0][SLOT_W-1:0] ptr_q;
  logic [SLOT_W-1:0]            top_q;

  logic [SLOT_W-1:0] xa, xb, adj_top;
  logic              tmp_v;
  logic [SLOT_W-1:0] tmp_p;

  assign adj_top   = SLOT_W'(top_step(32'(top_q), ret_tos_adj, NSLOT));
  assign ret_slot  = SLOT_W'(slot_add(32'(adj_top), 32'(ret_rel), NSLOT));
  assign ret_write = ret_valid && !ret_xch && ret_dst_en;
  assign xa        = top_q;
  assign xb        = SLOT_W'(slot_add(32'(top_q), 32'(ret_rel), NSLOT));

  always_comb begin
    nxt_val = val_q;
    nxt_ptr = ptr_q;
    nxt_top = top_q;
    tmp_v   = 1'b0;
    tmp_p   = '0;
    if (ret_valid) begin
      if (ret_xch) begin
        tmp_v       = nxt_val[xa];
        tmp_p       = nxt_ptr[xa];
        nxt_val[xa] = nxt_val[xb];
        nxt_ptr[xa] = nxt_ptr[xb];
        nxt_val[xb] = tmp_v;
        nxt_ptr[xb] = tmp_p;
      end else begin
        nxt_top = adj_top;
        if (ret_tos_adj == ADJ_POP) nxt_val[top_q] = 1'b0;
        if (ret_dst_en) nxt_val[ret_slot] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '1;
      top_q <= '0;
      for (int i = 0; i < NSLOT; i++) ptr_q[i] <= SLOT_W'(i);
    end else begin
      val_q <= nxt_val;
      ptr_q <= nxt_ptr;
      top_q <= nxt_top;
    end
  end

  // R6: without a retirement the nonspeculative state holds.
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> (val_q == $past(val_q)) && (ptr_q == $past(ptr_q)) && (top_q == $past(top_q)));

  // R6: a retiring exchange of the top with itself leaves the table as it was.
  p_self_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_xch && ret_rel == '0) |=> (val_q == $past(val_q)) && (ptr_q == $past(ptr_q)));

endmodule

// File: rtl/fpr_spec_table.sv
`timescale 1ns/1ps
module fpr_spec_table
  import fpr_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int SLOT_W = $clog2(NSLOT),
  parameter int TAG_W  = 6,
  parameter int PTR_W  = (TAG_W > SLOT_W) ? TAG_W : SLOT_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ren_valid,
  input  logic                         ren_xch,
  input  logic [SLOT_W-1:0]            ren_src_rel,
  input  logic                         ren_dst_en,
  input  logic [SLOT_W-1:0]            ren_dst_rel,
  input  logic [1:0]                   ren_tos_adj,
  input  logic [TAG_W-1:0]             ren_tag,
  input  logic                         flush,
  input  logic                         ret_write,
  input  logic [TAG_W-1:0]             ret_tag,
  input  logic [SLOT_W-1:0]            ret_slot,
  input  logic [NSLOT-1:0]             rt_val,
  input  logic [NSLOT-1:0][SLOT_W-1:0] rt_ptr,
  input  logic [SLOT_W-1:0]            rt_top,
  output logic                         look_val,
  output logic                         look_rob,
  output logic [PTR_W-1:0]             look_ptr,
  output logic [SLOT_W-1:0]            top
);

  logic [NSLOT-1:0]            sv_q, srob_q;
  logic [NSLOT-1:0][PTR_W-1:0] sptr_q;
  logic [SLOT_W-1:0]           top_q;

  logic [NSLOT-1:0]            sv_n, srob_n;
  logic [NSLOT-1:0][PTR_W-1:0] sptr_n;
  logic [SLOT_W-1:0]           top_n;

  // Named internal events for the checks below.
  logic [NSLOT-1:0]  retire_hit;
  logic [SLOT_W-1:0] src_idx, dst_idx, new_top;
  logic [PTR_W-1:0]  tag_ext, ret_tag_ext;
  logic              ren_act, ren_write;
  logic              tv, tr;
  logic [PTR_W-1:0]  tp;

  assign src_idx     = SLOT_W'(slot_add(32'(top_q), 32'(ren_src_rel), NSLOT));
  assign new_top     = SLOT_W'(top_step(32'(top_q), ren_tos_adj, NSLOT));
  assign dst_idx     = SLOT_W'(slot_add(32'(new_top), 32'(ren_dst_rel), NSLOT));
  assign tag_ext     = PTR_W'(ren_tag);
  assign ret_tag_ext = PTR_W'(ret_tag);
  assign ren_act     = ren_valid && !flush;
  assign ren_write   = ren_act && !ren_xch && ren_dst_en;

  assign look_val = sv_q[src_idx];
  assign look_rob = srob_q[src_idx];
  assign look_ptr = sptr_q[src_idx];
  assign top      = top_q;

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_hit
      assign retire_hit[g] = ret_write && srob_q[g] && (sptr_q[g] == ret_tag_ext);
    end
  endgenerate

  always_comb begin
    sv_n   = sv_q;
    srob_n = srob_q;
    sptr_n = sptr_q;
    top_n  = top_q;
    tv     = 1'b0;
    tr     = 1'b0;
    tp     = '0;
    if (flush) begin
      for (int i = 0; i < NSLOT; i++) begin
        sv_n[i]   = rt_val[i];
        srob_n[i] = 1'b0;
        sptr_n[i] = PTR_W'(rt_ptr[i]);
      end
      top_n = rt_top;
    end else begin
      // Retirement resets first; the rename below overrides them.
      for (int i = 0; i < NSLOT; i++) begin
        if (retire_hit[i]) begin
          srob_n[i] = 1'b0;
          sptr_n[i] = PTR_W'(rt_ptr[ret_slot]);
        end
      end
      if (ren_valid) begin
        if (ren_xch) begin
          tv              = sv_n[top_q];
          tr              = srob_n[top_q];
          tp              = sptr_n[top_q];
          sv_n[top_q]     = sv_n[src_idx];
          srob_n[top_q]   = srob_n[src_idx];
          sptr_n[top_q]   = sptr_n[src_idx];
          sv_n[src_idx]   = tv;
          srob_n[src_idx] = tr;
          sptr_n[src_idx] = tp;
        end else begin
          top_n = new_top;
          if (ren_tos_adj == ADJ_POP) sv_n[top_q] = 1'b0;
          if (ren_dst_en) begin
            sv_n[dst_idx]   = 1'b1;
            srob_n[dst_idx] = 1'b1;
            sptr_n[dst_idx] = tag_ext;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sv_q   <= '1;
      srob_q <= '0;
      top_q  <= '0;
      for (int i = 0; i < NSLOT; i++) sptr_q[i] <= PTR_W'(i);
    end else begin
      sv_q   <= sv_n;
      srob_q <= srob_n;
      sptr_q <= sptr_n;
      top_q  <= top_n;
    end
  end

  // R9: a flush adopts the retirement top of stack.
  p_flush_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> top_q == $past(rt_top));

  // R4: an exchange never moves the top of stack.
  p_xch_keeps_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_act && ren_xch) |=> top_q == $past(top_q));

  // R7: a rename write wins over any concurrent retirement reset.
  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ren_write |=> srob_q[$past(dst_idx)] && (sptr_q[$past(dst_idx)] == $past(tag_ext)));

  // R9: right after a flush nothing points into the reorder buffer.
  p_flush_clears_rob_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> srob_q == '0);

endmodule

// File: rtl/fpr_stack_rename.sv
`timescale 1ns/1ps
module fpr_stack_rename #(
  parameter int NSLOT = 8,
  parameter int TAG_W = 6,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int PTR_W  = (TAG_W > SLOT_W) ? TAG_W : SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_valid,
  input  logic              ren_xch,
  input  logic [SLOT_W-1:0] ren_src_rel,
  input  logic              ren_dst_en,
  input  logic [SLOT_W-1:0] ren_dst_rel,
  input  logic [1:0]        ren_tos_adj,
  input  logic [TAG_W-1:0]  ren_tag,
  output logic              ren_src_valid,
  output logic              ren_src_in_rob,
  output logic [PTR_W-1:0]  ren_src_ptr,
  output logic              ren_done,
  output logic [SLOT_W-1:0] spec_tos,
  input  logic              ret_valid,
  input  logic              ret_xch,
  input  logic [SLOT_W-1:0] ret_rel,
  input  logic              ret_dst_en,
  input  logic [1:0]        ret_tos_adj,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic              flush
);

  logic [NSLOT-1:0]             rt_val;
  logic [NSLOT-1:0][SLOT_W-1:0] rt_ptr;
  logic [SLOT_W-1:0]            rt_top, ret_slot;
  logic                         ret_write;
  logic                         look_val, look_rob;
  logic [PTR_W-1:0]             look_ptr;
  logic                         src_retiring;

  fpr_retire_table #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_rtab (
    .clk        (clk),
    .rst_n      (rst_n),
    .ret_valid  (ret_valid),
    .ret_xch    (ret_xch),
    .ret_rel    (ret_rel),
    .ret_dst_en (ret_dst_en),
    .ret_tos_adj(ret_tos_adj),
    .nxt_val    (rt_val),
    .nxt_ptr    (rt_ptr),
    .nxt_top    (rt_top),
    .ret_slot   (ret_slot),
    .ret_write  (ret_write)
  );

  fpr_spec_table #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .TAG_W(TAG_W), .PTR_W(PTR_W)) u_stab (
    .clk        (clk),
    .rst_n      (rst_n),
    .ren_valid  (ren_valid),
    .ren_xch    (ren_xch),
    .ren_src_rel(ren_src_rel),
    .ren_dst_en (ren_dst_en),
    .ren_dst_rel(ren_dst_rel),
    .ren_tos_adj(ren_tos_adj),
    .ren_tag    (ren_tag),
    .flush      (flush),
    .ret_write  (ret_write),
    .ret_tag    (ret_tag),
    .ret_slot   (ret_slot),
    .rt_val     (rt_val),
    .rt_ptr     (rt_ptr),
    .rt_top     (rt_top),
    .look_val   (look_val),
    .look_rob   (look_rob),
    .look_ptr   (look_ptr),
    .top        (spec_tos)
  );

  // Retirement override on the array read.
  assign src_retiring   = ret_write && look_rob && (look_ptr == PTR_W'(ret_tag));
  assign ren_src_valid  = look_val;
  assign ren_src_in_rob = look_rob && !src_retiring;
  assign ren_src_ptr    = src_retiring ? PTR_W'(rt_ptr[ret_slot]) : look_ptr;
  assign ren_done       = ren_valid && ren_xch && !flush;

  // R8: a source never names a tag that is retiring in the same cycle.
  p_no_stale_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_write |-> !(ren_src_in_rob && ren_src_ptr == PTR_W'(ret_tag)));

  // R5: a completed exchange leaves the speculative top unchanged.
  p_done_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ren_done |=> spec_tos == $past(spec_tos));

endmodule

// File: tb/sim_fpr_stack_rename.sv
`timescale 1ns/1ps
module sim_fpr_stack_rename;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ren_valid = 0, ren_xch = 0, ren_dst_en = 0;
  logic [2:0] ren_src_rel = 0, ren_dst_rel = 0;
  logic [1:0] ren_tos_adj = 0;
  logic [5:0] ren_tag = 0;
  logic       ren_src_valid, ren_src_in_rob, ren_done;
  logic [5:0] ren_src_ptr;
  logic [2:0] spec_tos;
  logic       ret_valid = 0, ret_xch = 0, ret_dst_en = 0, flush = 0;
  logic [2:0] ret_rel = 0;
  logic [1:0] ret_tos_adj = 0;
  logic [5:0] ret_tag = 0;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  // Bench model of both tables.
  int mv[8], mr[8], mp[8], mt;
  int rv_m[8], rp_m[8], rt_m;

  always #5 clk = ~clk;

  fpr_stack_rename u0 (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_xch(ren_xch),
    .ren_src_rel(ren_src_rel), .ren_dst_en(ren_dst_en), .ren_dst_rel(ren_dst_rel),
    .ren_tos_adj(ren_tos_adj), .ren_tag(ren_tag), .ren_src_valid(ren_src_valid),
    .ren_src_in_rob(ren_src_in_rob), .ren_src_ptr(ren_src_ptr), .ren_done(ren_done),
    .spec_tos(spec_tos), .ret_valid(ret_valid), .ret_xch(ret_xch), .ret_rel(ret_rel),
    .ret_dst_en(ret_dst_en), .ret_tos_adj(ret_tos_adj), .ret_tag(ret_tag), .flush(flush)
  );

  function automatic int step(input int t, input int adj);
    if (adj == 1) return (t + 7) % 8;
    if (adj == 2) return (t + 1) % 8;
    return t;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // One clock of stimulus: checks the same-cycle lookup, then the new top.
  task automatic cyc(input bit i_rv, input bit i_xch, input int i_srel, input bit i_den,
                     input int i_drel, input int i_adj, input int i_tag,
                     input bit i_tv, input bit i_txch, input int i_trel, input bit i_tden,
                     input int i_tadj, input int i_ttag, input bit i_fl, input string req);
    int nrv[8], nrp[8], nsv[8], nsr[8], nsp[8];
    int nrt, nst, s, rslot, ea, eb, tmp, ev, er, ep;
    bit rw;
    @(negedge clk);
    ren_valid = i_rv; ren_xch = i_xch; ren_src_rel = 3'(i_srel); ren_dst_en = i_den;
    ren_dst_rel = 3'(i_drel); ren_tos_adj = 2'(i_adj); ren_tag = 6'(i_tag);
    ret_valid = i_tv; ret_xch = i_txch; ret_rel = 3'(i_trel); ret_dst_en = i_tden;
    ret_tos_adj = 2'(i_tadj); ret_tag = 6'(i_ttag); flush = i_fl;
    // Retirement table after this cycle (R6).
    nrv = rv_m; nrp = rp_m; nrt = rt_m;
    if (i_tv) begin
      if (i_txch) begin
        ea = rt_m; eb = (rt_m + i_trel) % 8;
        tmp = nrv[ea]; nrv[ea] = nrv[eb]; nrv[eb] = tmp;
        tmp = nrp[ea]; nrp[ea] = nrp[eb]; nrp[eb] = tmp;
      end else begin
        nrt = step(rt_m, i_tadj);
        if (i_tadj == 2) nrv[rt_m] = 0;
        if (i_tden) nrv[(nrt + i_trel) % 8] = 1;
      end
    end
    rslot = (step(rt_m, i_tadj) + i_trel) % 8;
    rw = i_tv && !i_txch && i_tden;
    // Expected lookup with retirement override (R2, R8).
    s = (mt + i_srel) % 8;
    ev = mv[s]; er = mr[s]; ep = mp[s];
    if (rw && er == 1 && ep == i_ttag) begin er = 0; ep = nrp[rslot]; end
    // Speculative table after this cycle (R3, R4, R7, R9).
    nsv = mv; nsr = mr; nsp = mp; nst = mt;
    if (i_fl) begin
      for (int i = 0; i < 8; i++) begin nsv[i] = nrv[i]; nsr[i] = 0; nsp[i] = nrp[i]; end
      nst = nrt;
    end else begin
      for (int i = 0; i < 8; i++)
        if (rw && mr[i] == 1 && mp[i] == i_ttag) begin nsr[i] = 0; nsp[i] = nrp[rslot]; end
      if (i_rv) begin
        if (i_xch) begin
          ea = mt; eb = (mt + i_srel) % 8;
          tmp = nsv[ea]; nsv[ea] = nsv[eb]; nsv[eb] = tmp;
          tmp = nsr[ea]; nsr[ea] = nsr[eb]; nsr[eb] = tmp;
          tmp = nsp[ea]; nsp[ea] = nsp[eb]; nsp[eb] = tmp;
        end else begin
          nst = step(mt, i_adj);
          if (i_adj == 2) nsv[mt] = 0;
          if (i_den) begin
            s = (nst + i_drel) % 8;
            nsv[s] = 1; nsr[s] = 1; nsp[s] = i_tag;
          end
        end
      end
    end
    #1;
    chk(req, "src_valid", int'(ren_src_valid), ev);
    chk(req, "src_in_rob", int'(ren_src_in_rob), er);
    chk(req, "src_ptr", int'(ren_src_ptr), ep);
    chk("R5", "done", int'(ren_done), int'(i_rv && i_xch && !i_fl));
    @(posedge clk);
    mv = nsv; mr = nsr; mp = nsp; mt = nst;
    rv_m = nrv; rp_m = nrp; rt_m = nrt;
    #1;
    chk(req, "spec_tos", int'(spec_tos), mt);
  endtask

  task automatic look(input int srel, input string req);
    cyc(0, 0, srel, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic ren(input bit xch, input int srel, input bit den, input int drel,
                     input int adj, input int tag, input string req);
    cyc(1, xch, srel, den, drel, adj, tag, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic ret(input bit txch, input int trel, input bit tden, input int tadj,
                     input int ttag, input string req);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, txch, trel, tden, tadj, ttag, 0, req);
  endtask

  task automatic t_reset_state();
    chk("R1", "tos after reset", int'(spec_tos), 0);
    for (int r = 0; r < 8; r++) look(r, "R1");
  endtask

  task automatic t_push_write();
    ren(0, 3, 1, 0, 1, 10, "R3");   // push, write tag 10 at new top 7
    ren(0, 0, 1, 0, 1, 11, "R3");   // push, write tag 11 at new top 6
    look(1, "R2");                   // slot 7 holds tag 10
    ren(0, 2, 1, 2, 3, 12, "R3");   // adj 3 keeps top; tag 12 at slot 0
    look(2, "R2");
  endtask

  task automatic t_exchange();
    ren(1, 1, 0, 0, 1, 0, "R4");    // swap slots 6 and 7; push field ignored
    look(0, "R4");
    look(1, "R4");
    ren(1, 0, 0, 0, 0, 0, "R4");    // exchange top with itself
    look(0, "R4");
  endtask

  task automatic t_pop();
    ren(0, 0, 0, 0, 2, 0, "R3");    // pop: top 6 -> 7, slot 6 emptied
    look(7, "R3");
  endtask

  task automatic t_retire_same_cycle();
    // Retire tag 10 (push, rel 0) while slot 6 holding it is looked up.
    cyc(0, 0, 7, 0, 0, 0, 0, 1, 0, 0, 1, 1, 10, 0, "R8");
    look(7, "R7");
    // Rename writes tag 20 into slot 7 while its tag 11 retires.
    cyc(1, 0, 0, 1, 0, 0, 20, 1, 0, 0, 1, 1, 11, 0, "R7");
    look(0, "R7");
  endtask

  task automatic t_flush();
    ret(1, 1, 0, 0, 0, "R6");        // retiring exchange: slots 6 and 7 swapped
    ret(0, 0, 0, 2, 0, "R6");        // retiring pop clears old top
    ret(1, 0, 0, 0, 0, "R6");        // retiring self exchange
    // Flush together with a push rename and a retiring push write.
    cyc(1, 0, 0, 1, 0, 1, 33, 1, 0, 1, 1, 1, 40, 1, "R9");
    for (int r = 0; r < 8; r++) look(r, "R9");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      mv[i] = 1; mr[i] = 0; mp[i] = i; rv_m[i] = 1; rp_m[i] = i;
    end
    mt = 0; rt_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    t_reset_state();
    t_push_write();
    t_exchange();
    t_pop();
    t_retire_same_cycle();
    t_flush();
    summary();
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule